// File: doc/BRIEF.md
# Depth-Cascadable FIFO Slice with Token Handoff

This block is one slice of a deep first-in/first-out buffer built by chaining identical slices into a ring. Each slice holds a small array of 9-bit words with its own write and read pointers, an occupancy count, and local empty and full flags. There is no shared address decoder. Instead, two ownership tokens travel around the ring. The slice that holds the write token takes the writes, and the slice that holds the read token serves the reads.

A slice gives up a token when it accesses its last physical location. At that point it drives a two-bit handoff code on `hop_out`, which is wired to `hop_in` of the next slice in the ring. The receiving slice takes the token at the next clock edge and resumes at its location zero. After reset, exactly one slice is marked with `lead_slice` and owns both tokens. System-level full and empty indications are formed outside the slice by combining the local flags. Half-full tracking and replay of already-read data are not part of this mode.

The slice runs on a single clock with a synchronous active-low reset. Strobes are sampled at the rising edge. The read word is presented combinationally from the current read location, in show-ahead style.

Top module: `ring_fifo_slice`

## Requirements
- R1: While `rst_n` is low at a rising edge, both pointers return to location zero, the occupancy becomes zero, `empty` reads 1 and `full` reads 0.
- R2: The value of `lead_slice` at a reset edge decides token ownership: 1 gives the slice both tokens, and 0 leaves it with neither.
- R3: A write is accepted at a rising edge when `wr_en` is 1, the slice owns the write token and `full` is 0. The word is stored at the write pointer and later read back in the order it was written.
- R4: While the slice owns the read token and `empty` is 0, `rd_data` shows the word at the read pointer. Otherwise `rd_data` is zero. An accepted read (`rd_en` with the token, not empty) advances the read pointer.
- R5: An accepted write to location DEPTH-1 sets `hop_out` to 2'b01 in that same cycle, wraps the write pointer to zero and releases the write token.
- R6: An accepted read from location DEPTH-1 sets `hop_out` to 2'b10 in that same cycle, wraps the read pointer to zero and releases the read token.
- R7: Outside those cycles `hop_out` is 2'b00. Bit 0 only ever means a write handoff and bit 1 only ever means a read handoff, and at most one bit is set in any cycle.
- R8: `hop_in` bit 0 set at a rising edge grants the write token, and bit 1 grants the read token. A grant takes precedence over a release in the same cycle.
- R9: A write strobe is ignored when the slice lacks the write token or is full. Neither the stored data nor the occupancy changes.
- R10: A read strobe is ignored when the slice lacks the read token or is empty. The read pointer does not move.
- R11: `empty` is 1 exactly when the occupancy is zero, and `full` is 1 exactly when it equals DEPTH. A read and a write accepted together leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| lead_slice | input | 1 | Sampled during reset; 1 makes this slice the initial owner of both tokens |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH | Word to be written |
| rd_en | input | 1 | Read strobe |
| hop_in | input | 2 | Handoff code from the previous slice (bit 0 write, bit 1 read) |
| rd_data | output | WIDTH | Oldest word while the read token is held and not empty, else zero |
| empty | output | 1 | Local occupancy is zero |
| full | output | 1 | Local occupancy equals DEPTH |
| hop_out | output | 2 | Handoff code to the next slice (bit 0 write, bit 1 read) |

## Verification
The hardest situation to reach is a slice that is partly filled from an older lap of the ring and still has unread words, while the tokens have moved on and come back. In that state, pointer wrap, token release and token grant all meet in a few cycles. The stimulus drives `hop_in` directly in place of the neighbouring slices. It fills the slice to its last location, lets both pointers wrap, and returns each token by hand. It then reaches a cycle where a read releases the read token while `hop_in` returns both tokens at once. A second reset with `lead_slice` low shows that writes are refused until a grant arrives.

// File: rtl/ring_fifo_pkg.sv
package ring_fifo_pkg;

  localparam int HOP_WR_BIT = 0;
  localparam int HOP_RD_BIT = 1;

  typedef logic [1:0] hop_t;

  // Build the handoff code from the two independent last-location events.
  function automatic hop_t hop_code(input logic wr_hop, input logic rd_hop);
    hop_t c;
    c = '0;
    c[HOP_WR_BIT] = wr_hop;
    c[HOP_RD_BIT] = rd_hop;
    return c;
  endfunction

endpackage

// File: rtl/ring_ptr.sv
module ring_ptr #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [AW-1:0] ptr,
  output logic          at_last
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign at_last = (ptr == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= step(ptr);
  end

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && at_last) |=> (ptr == '0));  // R5

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr));  // R10

endmodule

// File: rtl/ring_token.sv
module ring_token (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic drop,
  input  logic grant,
  output logic own
);

  always_ff @(posedge clk) begin
    if (!rst_n) own <= init;
    else        own <= (own & ~drop) | grant;
  end

  AST_TOKEN_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> own);  // R8

  AST_TOKEN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !grant) |=> !own);  // R6

endmodule

// File: rtl/ring_store.sv
module ring_store #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 9,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/ring_fifo_slice.sv
module ring_fifo_slice
  import ring_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lead_slice,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [1:0]       hop_in,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full,
  output logic [1:0]       hop_out
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic          wr_tok, rd_tok;
  logic [AW-1:0] wptr, rptr;
  logic          w_last, r_last;
  logic          wr_acc, rd_acc;
  logic          wr_hop, rd_hop;
  logic [CW-1:0] occ;
  logic [WIDTH-1:0] store_q;

  function automatic logic [CW-1:0] occ_step(input logic [CW-1:0] c,
                                             input logic inc, input logic dec);
    case ({inc, dec})
      2'b10:   return c + 1'b1;
      2'b01:   return c - 1'b1;
      default: return c;
    endcase
  endfunction

  assign empty  = (occ == '0);
  assign full   = (occ == FULL_CNT);
  assign wr_acc = wr_en & wr_tok & ~full;
  assign rd_acc = rd_en & rd_tok & ~empty;
  assign wr_hop = wr_acc & w_last;
  assign rd_hop = rd_acc & r_last;
  assign hop_out = hop_code(wr_hop, rd_hop);
  assign rd_data = (rd_tok && !empty) ? store_q : '0;

  ring_token u_wtok (
    .clk(clk), .rst_n(rst_n), .init(lead_slice),
    .drop(wr_hop), .grant(hop_in[HOP_WR_BIT]), .own(wr_tok)
  );

  ring_token u_rtok (
    .clk(clk), .rst_n(rst_n), .init(lead_slice),
    .drop(rd_hop), .grant(hop_in[HOP_RD_BIT]), .own(rd_tok)
  );

  ring_ptr #(.DEPTH(DEPTH)) u_wptr (
    .clk(clk), .rst_n(rst_n), .adv(wr_acc), .ptr(wptr), .at_last(w_last)
  );

  ring_ptr #(.DEPTH(DEPTH)) u_rptr (
    .clk(clk), .rst_n(rst_n), .adv(rd_acc), .ptr(rptr), .at_last(r_last)
  );

  ring_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .we(wr_acc), .waddr(wptr), .wdata(wr_data),
    .raddr(rptr), .rdata(store_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ_step(occ, wr_acc, rd_acc);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= FULL_CNT);  // R11

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_acc) |=> full);  // R9

  AST_EMPTY_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    empty |=> $stable(rptr));  // R10

  AST_HOP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hop_out));  // R7

  AST_WR_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    hop_out[HOP_WR_BIT] |=> (wptr == '0));  // R5

endmodule

// File: tb/ring_fifo_slice_tb.sv
module ring_fifo_slice_tb;

  localparam int DEPTH = 4;
  localparam int WIDTH = 9;
  localparam int NVEC  = 19;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             lead_slice = 1'b1;
  logic             wr_en = 1'b0;
  logic [WIDTH-1:0] wr_data = '0;
  logic             rd_en = 1'b0;
  logic [1:0]       hop_in = 2'b00;
  logic [WIDTH-1:0] rd_data;
  logic             empty, full;
  logic [1:0]       hop_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ring_fifo_slice #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .lead_slice(lead_slice), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .hop_in(hop_in), .rd_data(rd_data),
    .empty(empty), .full(full), .hop_out(hop_out)
  );

  // {wr_en, rd_en, hop_in, wr_data | exp hop_out, exp empty, exp full, exp rd_data}
  localparam logic [25:0] VEC [NVEC] = '{
    {1'b1,1'b0,2'b00,9'h101, 2'b00,1'b1,1'b0,9'h000},
    {1'b1,1'b0,2'b00,9'h102, 2'b00,1'b0,1'b0,9'h101},
    {1'b1,1'b0,2'b00,9'h103, 2'b00,1'b0,1'b0,9'h101},
    {1'b1,1'b0,2'b00,9'h1FF, 2'b01,1'b0,1'b0,9'h101},
    {1'b1,1'b0,2'b00,9'h0AA, 2'b00,1'b0,1'b1,9'h101},
    {1'b0,1'b1,2'b00,9'h000, 2'b00,1'b0,1'b1,9'h101},
    {1'b1,1'b0,2'b00,9'h055, 2'b00,1'b0,1'b0,9'h102},
    {1'b0,1'b0,2'b01,9'h000, 2'b00,1'b0,1'b0,9'h102},
    {1'b1,1'b1,2'b00,9'h077, 2'b00,1'b0,1'b0,9'h102},
    {1'b0,1'b1,2'b00,9'h000, 2'b00,1'b0,1'b0,9'h103},
    {1'b1,1'b1,2'b00,9'h011, 2'b10,1'b0,1'b0,9'h1FF},
    {1'b0,1'b1,2'b00,9'h000, 2'b00,1'b0,1'b0,9'h000},
    {1'b0,1'b0,2'b10,9'h000, 2'b00,1'b0,1'b0,9'h000},
    {1'b0,1'b1,2'b00,9'h000, 2'b00,1'b0,1'b0,9'h077},
    {1'b1,1'b1,2'b00,9'h022, 2'b00,1'b0,1'b0,9'h011},
    {1'b1,1'b1,2'b00,9'h033, 2'b01,1'b0,1'b0,9'h022},
    {1'b0,1'b1,2'b11,9'h000, 2'b10,1'b0,1'b0,9'h033},
    {1'b1,1'b1,2'b00,9'h044, 2'b00,1'b1,1'b0,9'h000},
    {1'b0,1'b0,2'b00,9'h000, 2'b00,1'b0,1'b0,9'h044}
  };

  function automatic string vec_req(input int i);
    case (i)
      0, 1, 2:  return "R3 write accept";
      3:        return "R5 write last location handoff";
      4:        return "R9 write while full and tokenless";
      5:        return "R4 read advance";
      6:        return "R9 write without token";
      7:        return "R8 write grant";
      8, 9:     return "R11 concurrent read write";
      10:       return "R6 read last location handoff";
      11:       return "R10 read without token";
      12:       return "R8 read grant";
      13, 14:   return "R4 order after wrap";
      15:       return "R7 write hop code";
      16:       return "R8 grant beats release";
      17:       return "R10 read while empty";
      default:  return "R3 data after regrant";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic drive(input logic we, input logic re, input logic [1:0] hi,
                       input logic [WIDTH-1:0] wd);
    @(negedge clk);
    wr_en = we; rd_en = re; hop_in = hi; wr_data = wd;
    #2;
  endtask

  initial begin
    #(20 * 5000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; lead_slice = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check("R1 reset empty", 32'(empty), 32'd1);
    check("R1 reset full", 32'(full), 32'd0);
    check("R7 reset hop_out idle", 32'(hop_out), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][25], VEC[i][24], VEC[i][23:22], VEC[i][21:13]);
      check({vec_req(i), " hop_out"}, 32'(hop_out), 32'(VEC[i][12:11]));
      check({vec_req(i), " empty"},   32'(empty),   32'(VEC[i][10]));
      check({vec_req(i), " full"},    32'(full),    32'(VEC[i][9]));
      check({vec_req(i), " rd_data"}, 32'(rd_data), 32'(VEC[i][8:0]));
    end

    // Second reset as a non-lead slice, with data still held from above.
    @(negedge clk);
    rst_n = 1'b0; lead_slice = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; hop_in = 2'b00;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    lead_slice = 1'b1;
    #2;
    check("R1 reset clears occupancy", 32'(empty), 32'd1);
    check("R2 no read token rd_data", 32'(rd_data), 32'd0);

    drive(1'b1, 1'b0, 2'b00, 9'h1A5);
    check("R2 tokenless write no hop", 32'(hop_out), 32'd0);
    drive(1'b0, 1'b0, 2'b00, 9'h000);
    check("R2 tokenless write ignored", 32'(empty), 32'd1);

    drive(1'b0, 1'b0, 2'b01, 9'h000);
    drive(1'b1, 1'b0, 2'b00, 9'h15A);
    drive(1'b0, 1'b0, 2'b00, 9'h000);
    check("R8 granted write accepted", 32'(empty), 32'd0);
    check("R4 data hidden without read token", 32'(rd_data), 32'd0);

    drive(1'b0, 1'b0, 2'b10, 9'h000);
    drive(1'b0, 1'b0, 2'b00, 9'h000);
    check("R1 pointers restart at zero", 32'(rd_data), 32'h15A);
    drive(1'b0, 1'b1, 2'b00, 9'h000);
    drive(1'b0, 1'b0, 2'b00, 9'h000);
    check("R11 empty after last read", 32'(empty), 32'd1);

    finish_run();
  end

endmodule